// File: doc/BRIEF.md
# Arbitrated Dual-Port Mailbox Memory

A byte-wide shared store with two independent access ports, called left and right. Each port has its own select, write-enable, address, write data and read data. Both sides address the same locations, so a value stored through one port can be fetched through the other. The array is split by the most significant address bit into two one-way mailboxes. The upper half carries traffic from left to right, so only the left port may store there. The lower half carries traffic from right to left, so only the right port may store there. Reads are accepted anywhere.

When both ports select one location in the same cycle and at least one of them is writing, an arbiter lets one access through. It raises a combinational busy flag to the other port, which must present the same request again in the next cycle. A stalled port is served first on its retry, so no port is ever held off for two cycles in a row. A per-port ready-stretch machine turns each busy into exactly one clock of deasserted ready, the single wait state that a bus interface inserts.

The arbiter has three states. `ARB_EVEN` means no port is waiting, and a tie goes to left. `ARB_LEFT_HELD` means left was stalled last cycle, so left wins now. `ARB_RIGHT_HELD` means right was stalled last cycle, so right wins now. Every cycle the arbiter moves to `ARB_LEFT_HELD` if left is busy, to `ARB_RIGHT_HELD` if right is busy, and otherwise to `ARB_EVEN`. Each ready-stretch machine has two states. It moves from `RS_RUN` to `RS_WAIT` on a busy cycle, and from `RS_WAIT` back to `RS_RUN` unconditionally.

Top module: `dpmb_mailbox`

## Requirements
- R1: Accesses of the two ports to different addresses never raise busy, and both complete in the same cycle.
- R2: A left write stores only when address bit 9 is 1 (upper half). A left write with bit 9 equal to 0 leaves the location unchanged.
- R3: A right write stores only when address bit 9 is 0 (lower half). A right write with bit 9 equal to 1 leaves the location unchanged.
- R4: Contention is when both selects are high with equal addresses and at least one write-enable is high. Only then is a busy raised, and never to both ports at once. Two reads of one address proceed without busy.
- R5: On contention while no port is waiting, left proceeds and right receives busy in that same cycle.
- R6: A port that received busy in one cycle and repeats its request in the next cycle wins that cycle. No port sees busy in two consecutive cycles.
- R7: A read stalled behind a contending write returns, on its retry, the data that write stored.
- R8: A port's ready output is low for exactly one cycle, the cycle after the one in which its busy was high.
- R9: During and right after reset, both busy outputs are 0, both ready outputs are 1 and both read-data outputs are 0.
- R10: A granted read presents data after the clock edge that ends its cycle. Read data holds its value while no granted read occurs on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left write enable |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_busy | output | 1 | Left access held off this cycle |
| l_ready | output | 1 | Left ready, low for one wait state |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right write enable |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_busy | output | 1 | Right access held off this cycle |
| r_ready | output | 1 | Right ready, low for one wait state |

## Verification
Busy depends only on the current inputs and the arbiter state, so the bench samples it 1 ns after driving the inputs on the falling edge, before the next rising edge. Read data and ready change on the rising edge that ends the request cycle, so the bench samples them 1 ns after that edge. Each result is therefore checked in the cycle it is due and never one cycle late. Stalled requests are repeated on the next falling edge, and the retry result is sampled one edge later.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    typedef enum logic [1:0] {
        ARB_EVEN       = 2'd0,
        ARB_LEFT_HELD  = 2'd1,
        ARB_RIGHT_HELD = 2'd2
    } arb_state_t;

    typedef enum logic {
        RS_RUN  = 1'b0,
        RS_WAIT = 1'b1
    } rs_state_t;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/dpmb_arbiter.sv
module dpmb_arbiter
    import dpmb_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy,
    output logic              r_busy,
    output logic              l_grant,
    output logic              r_grant
);

    arb_state_t state_q;
    arb_state_t state_d;
    logic       clash;

    assign clash = l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: who is held off this cycle
    always_comb begin
        l_busy = 1'b0;
        r_busy = 1'b0;
        unique case (state_q)
            ARB_EVEN:       r_busy = clash;
            ARB_LEFT_HELD:  r_busy = clash;
            ARB_RIGHT_HELD: l_busy = clash;
            default: begin
                l_busy = 1'b0;
                r_busy = 1'b0;
            end
        endcase
        l_grant = l_cs && !l_busy;
        r_grant = r_cs && !r_busy;
    end

    // next state: remember the port that waited
    always_comb begin
        state_d = ARB_EVEN;
        if (l_busy) begin
            state_d = ARB_LEFT_HELD;
        end else if (r_busy) begin
            state_d = ARB_RIGHT_HELD;
        end
    end

endmodule

// File: rtl/dpmb_ready_stretch.sv
module dpmb_ready_stretch
    import dpmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic ready
);

    rs_state_t state_q;
    rs_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ready   = 1'b1;
        unique case (state_q)
            RS_RUN: begin
                ready = 1'b1;
                if (busy) begin
                    state_d = RS_WAIT;
                end
            end
            RS_WAIT: begin
                ready   = 1'b0;
                state_d = RS_RUN;
            end
            default: begin
                ready   = 1'b1;
                state_d = RS_RUN;
            end
        endcase
    end

endmodule

// File: rtl/dpmb_array.sv
module dpmb_array #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_grant,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_grant,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam int unsigned HALF_BIT = ADDR_W - 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              l_store;
    logic              r_store;
    logic              l_fetch;
    logic              r_fetch;

    // left owns the upper mailbox, right owns the lower one
    assign l_store = l_grant && l_we && l_addr[HALF_BIT];
    assign r_store = r_grant && r_we && !r_addr[HALF_BIT];
    assign l_fetch = l_grant && !l_we;
    assign r_fetch = r_grant && !r_we;

    always_ff @(posedge clk) begin
        if (l_store) begin
            mem[l_addr] <= l_wdata;
        end
        if (r_store) begin
            mem[r_addr] <= r_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_fetch) begin
                l_rdata <= mem[l_addr];
            end
            if (r_fetch) begin
                r_rdata <= mem[r_addr];
            end
        end
    end

endmodule

// File: rtl/dpmb_mailbox.sv
module dpmb_mailbox
    import dpmb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy,
    output logic              l_ready,
    input  logic              r_cs,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy,
    output logic              r_ready
);

    logic                 l_grant;
    logic                 r_grant;
    logic [NUM_PORTS-1:0] busy_vec;
    logic [NUM_PORTS-1:0] ready_vec;

    dpmb_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_cs    (l_cs),
        .l_we    (l_we),
        .l_addr  (l_addr),
        .r_cs    (r_cs),
        .r_we    (r_we),
        .r_addr  (r_addr),
        .l_busy  (l_busy),
        .r_busy  (r_busy),
        .l_grant (l_grant),
        .r_grant (r_grant)
    );

    assign busy_vec[PORT_L] = l_busy;
    assign busy_vec[PORT_R] = r_busy;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_stretch
        dpmb_ready_stretch rs_i (
            .clk   (clk),
            .rst_n (rst_n),
            .busy  (busy_vec[p]),
            .ready (ready_vec[p])
        );
    end

    assign l_ready = ready_vec[PORT_L];
    assign r_ready = ready_vec[PORT_R];

    dpmb_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_grant (l_grant),
        .l_we    (l_we),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_grant (r_grant),
        .r_we    (r_we),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

endmodule

// File: rtl/dpmb_mailbox_chk.sv
module dpmb_mailbox_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy,
    input logic              l_ready,
    input logic              r_cs,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy,
    input logic              r_ready
);

    logic clash;
    logic waited_q;

    assign clash = l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waited_q <= 1'b0;
        end else begin
            waited_q <= l_busy || r_busy;
        end
    end

    assert_busy_needs_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy || r_busy) |-> clash);

    assert_busy_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy && r_busy));

    assert_tie_to_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && !waited_q) |-> (r_busy && !l_busy));

    assert_left_retry_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy |=> !l_busy);

    assert_right_retry_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |=> !r_busy);

    assert_left_wait_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy |=> !l_ready);

    assert_right_wait_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |=> !r_ready);

    assert_left_one_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !l_ready |=> l_ready);

    assert_right_one_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_ready |=> r_ready);

endmodule

bind dpmb_mailbox dpmb_mailbox_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_cs    (l_cs),
    .l_we    (l_we),
    .l_addr  (l_addr),
    .l_busy  (l_busy),
    .l_ready (l_ready),
    .r_cs    (r_cs),
    .r_we    (r_we),
    .r_addr  (r_addr),
    .r_busy  (r_busy),
    .r_ready (r_ready)
);

// File: tb/dpmb_mailbox_tb_top.sv
`timescale 1ns/1ps
module dpmb_mailbox_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_cs = 1'b0, l_we = 1'b0;
    logic [9:0] l_addr = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       l_busy, l_ready;
    logic       r_cs = 1'b0, r_we = 1'b0;
    logic [9:0] r_addr = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;
    logic       r_busy, r_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dpmb_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy(l_busy), .l_ready(l_ready),
        .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy(r_busy), .r_ready(r_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // drive both ports on the falling edge, then let busy settle
    task automatic drive(input logic lc, input logic lw, input logic [9:0] la, input logic [7:0] ld,
                         input logic rc, input logic rw, input logic [9:0] ra, input logic [7:0] rd);
        @(negedge clk);
        l_cs = lc; l_we = lw; l_addr = la; l_wdata = ld;
        r_cs = rc; r_we = rw; r_addr = ra; r_wdata = rd;
        #1;
    endtask

    task automatic edge_done();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 0, '0, '0, 0, 0, '0, '0);
        edge_done();
    endtask

    task automatic t_reset();
        chk("R9", "l_busy", l_busy, 0);
        chk("R9", "r_busy", r_busy, 0);
        chk("R9", "l_ready", l_ready, 1);
        chk("R9", "r_ready", r_ready, 1);
        chk("R9", "l_rdata", l_rdata, 0);
        chk("R9", "r_rdata", r_rdata, 0);
    endtask

    task automatic t_independent();
        drive(1, 1, 10'h200, 8'hA5, 1, 1, 10'h010, 8'h3C);
        chk("R1", "l_busy", l_busy, 0);
        chk("R1", "r_busy", r_busy, 0);
        edge_done();
        drive(1, 0, 10'h010, 8'h00, 1, 0, 10'h200, 8'h00);
        chk("R1", "r_busy on reads", r_busy, 0);
        edge_done();
        chk("R3", "l_rdata lower", l_rdata, 8'h3C);
        chk("R2", "r_rdata upper", r_rdata, 8'hA5);
        idle();
        chk("R10", "l_rdata held", l_rdata, 8'h3C);
        chk("R10", "r_rdata held", r_rdata, 8'hA5);
    endtask

    task automatic t_dropped();
        drive(1, 1, 10'h010, 8'hFF, 1, 1, 10'h200, 8'h00);
        edge_done();
        drive(1, 0, 10'h010, 8'h00, 1, 0, 10'h200, 8'h00);
        edge_done();
        chk("R2", "left write to lower half ignored", l_rdata, 8'h3C);
        chk("R3", "right write to upper half ignored", r_rdata, 8'hA5);
        idle();
    endtask

    task automatic t_two_reads();
        drive(1, 0, 10'h200, 8'h00, 1, 0, 10'h200, 8'h00);
        chk("R4", "l_busy two reads", l_busy, 0);
        chk("R4", "r_busy two reads", r_busy, 0);
        edge_done();
        chk("R4", "l_rdata two reads", l_rdata, 8'hA5);
        chk("R4", "r_rdata two reads", r_rdata, 8'hA5);
        idle();
    endtask

    task automatic t_tie();
        drive(1, 1, 10'h300, 8'h77, 1, 0, 10'h300, 8'h00);
        chk("R5", "r_busy on tie", r_busy, 1);
        chk("R5", "l_busy on tie", l_busy, 0);
        edge_done();
        chk("R8", "r_ready after busy", r_ready, 0);
        chk("R8", "l_ready untouched", l_ready, 1);
        drive(0, 0, '0, '0, 1, 0, 10'h300, 8'h00);
        chk("R6", "r_busy on retry", r_busy, 0);
        edge_done();
        chk("R7", "r_rdata after stall", r_rdata, 8'h77);
        chk("R8", "r_ready back after one state", r_ready, 1);
        idle();
    endtask

    task automatic t_left_reader_tie();
        drive(0, 0, '0, '0, 1, 1, 10'h020, 8'h01);
        edge_done();
        idle();
        drive(1, 0, 10'h020, 8'h00, 1, 1, 10'h020, 8'h9A);
        chk("R5", "r_busy right writer loses tie", r_busy, 1);
        edge_done();
        chk("R5", "l_rdata reads old value", l_rdata, 8'h01);
        drive(0, 0, '0, '0, 1, 1, 10'h020, 8'h9A);
        chk("R6", "r_busy retry write", r_busy, 0);
        edge_done();
        drive(1, 0, 10'h020, 8'h00, 0, 0, '0, '0);
        edge_done();
        chk("R7", "l_rdata after stalled write", l_rdata, 8'h9A);
        idle();
    endtask

    task automatic t_held_priority();
        drive(1, 1, 10'h301, 8'h11, 1, 0, 10'h301, 8'h00);
        chk("R5", "r_busy first clash", r_busy, 1);
        edge_done();
        drive(1, 1, 10'h301, 8'h22, 1, 0, 10'h301, 8'h00);
        chk("R6", "l_busy waiting right wins", l_busy, 1);
        chk("R6", "r_busy waiting right wins", r_busy, 0);
        edge_done();
        chk("R7", "r_rdata sees first write", r_rdata, 8'h11);
        chk("R8", "l_ready dropped", l_ready, 0);
        chk("R8", "r_ready restored", r_ready, 1);
        drive(1, 1, 10'h301, 8'h22, 0, 0, '0, '0);
        chk("R6", "l_busy retry", l_busy, 0);
        edge_done();
        chk("R8", "l_ready restored", l_ready, 1);
        drive(0, 0, '0, '0, 1, 0, 10'h301, 8'h00);
        edge_done();
        chk("R7", "r_rdata sees retried write", r_rdata, 8'h22);
        idle();
    endtask

    initial begin
        #35;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        edge_done();
        t_reset();
        t_independent();
        t_dropped();
        t_two_reads();
        t_tie();
        t_left_reader_tie();
        t_held_priority();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule